// File: doc/BRIEF.md
# Attribute-Driven Posted Write Buffer

This block sits between a processor core and an external memory bus. It holds stores until they are written out. Each store carries two attribute bits, bufferable (B) and cacheable (C). Together with a two-bit control register, these bits decide what happens to the store: it is posted and the core moves on, it is merged with neighbouring words into one burst, or the core is held until the store has reached memory.

The core offers one word per cycle with `st_valid_i`. A store is taken on a rising clock edge where `stall_o` is low. A store-multiple sequence marks each of its words with `st_multi_i` and marks its final word with `st_last_i`.

Towards memory the block presents the oldest queued entry: a start address, up to eight data words, a word count and a burst flag. The entry stays on the bus until `mem_done_i` acknowledges it. A drain command pushes out everything held, including a partly built merge, and then reports completion with a one-cycle pulse.

Top module: `attr_wbuf`

## Requirements
- R1: When the buffer is effectively enabled, a store with B=1, C=0 and no store-multiple flag is taken in the cycle it is offered, provided the queue is not full and no merge is open. It later reaches memory as an entry with length 1 and the burst flag low.
- R2: Each word of a B=1, C=0 store-multiple sequence becomes its own entry of length 1. No word of such a sequence waits on memory.
- R3: A store is synchronous when the buffer is not effectively enabled, or when the store has B=0, C=0. A synchronous store is taken only after every earlier entry has been acknowledged and its own single-word write has been acknowledged.
- R4: Consecutive words of a B=0, C=1 store-multiple sequence are collected into one entry. The entry address is the first word's address, word i sits at `mem_data_o[32*i +: 32]`, the length equals the word count, and `mem_burst_o` is high exactly when the length is above 1.
- R5: A merge is closed by the word flagged `st_last_i` or by the word at line offset 7 (address bits [4:2] equal to 7). A word whose address is not the previous address plus 4 starts a new entry, and so does a word in a different 32-byte line.
- R6: The effective enable is the AND of the MMU bit `ctrl_mmu_en_i` and the buffer bit `ctrl_wb_en_i`, both latched on `ctrl_we_i`, and both may be set in a single write. Both bits reset to 0.
- R7: Clearing the enable does not drop queued entries. All of them still reach memory, and later stores are synchronous.
- R8: After a `drain_i` pulse, stores are held off and any open merge is queued. `drain_done_o` pulses for exactly one cycle once nothing is left to write.
- R9: The queue holds 8 entries. While it is full, a posted store is stalled until an acknowledge frees a slot.
- R10: Entries reach memory in the order they were formed. Address, length and data hold steady while `mem_req_o` is high and `mem_done_i` is low.
- R11: After reset, `mem_req_o` and `drain_done_o` are low, and `stall_o` is low while no store is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_mmu_en_i | input | 1 | MMU enable bit value |
| ctrl_wb_en_i | input | 1 | Buffer enable bit value |
| st_valid_i | input | 1 | Store offered |
| st_addr_i | input | 32 | Store word address |
| st_data_i | input | 32 | Store data |
| st_b_i | input | 1 | Bufferable attribute |
| st_c_i | input | 1 | Cacheable attribute |
| st_multi_i | input | 1 | Word belongs to a store-multiple sequence |
| st_last_i | input | 1 | Final word of a store-multiple sequence |
| stall_o | output | 1 | Offered store not taken this cycle |
| drain_i | input | 1 | Drain command pulse |
| drain_done_o | output | 1 | Drain complete pulse |
| mem_req_o | output | 1 | Entry presented to memory |
| mem_addr_o | output | 32 | Entry start address |
| mem_data_o | output | 256 | Entry data, word i at bits 32*i+31:32*i |
| mem_len_o | output | 4 | Entry word count |
| mem_burst_o | output | 1 | Entry is a burst |
| mem_done_i | input | 1 | Memory acknowledges the presented entry |

## Verification
The hardest state to reach from the ports is a store that arrives while a merge is still open but cannot join it. The store may be a word in a new line, a word that skips an address, a posted store or a synchronous store. In each case the buffer must queue the partial merge first and then deal with the newcomer. The stimulus gets there by leaving store-multiple sequences without their last flag and following them with each of these kinds of store. The full-queue stall is reached by holding back the memory acknowledge while eight posted stores go in. The disable-with-pending-entries case uses the same held acknowledge around a control write.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int LINE_WORDS = 8;
  localparam int CNT_W      = $clog2(LINE_WORDS + 1);
  localparam int OFS_W      = $clog2(LINE_WORDS);
  localparam int LINE_LSB   = OFS_W + 2;

  typedef struct packed {
    logic [ADDR_W-1:0]                  addr;
    logic [LINE_WORDS-1:0][DATA_W-1:0]  data;
    logic [CNT_W-1:0]                   cnt;
    logic                               burst;
  } wb_entry_t;

  typedef enum logic [1:0] {CLS_POST, CLS_MERGE, CLS_SYNC} st_class_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo import wbuf_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  wb_entry_t push_e_i,
  input  logic      pop_i,
  output wb_entry_t head_o,
  output logic      empty_o,
  output logic      full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  wb_entry_t      store_q [DEPTH];
  logic [PW-1:0]  wr_q, rd_q;
  logic [PW:0]    cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) store_q[wr_q] <= push_e_i;
  end

  assign head_o  = store_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wbuf_front.sv
module wbuf_front import wbuf_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_b_i,
  input  logic              st_c_i,
  input  logic              st_multi_i,
  input  logic              st_last_i,
  input  logic              drain_i,
  input  logic              q_full_i,
  input  logic              q_empty_i,
  output logic              stall_o,
  output logic              push_o,
  output wb_entry_t         push_e_o,
  output logic              drain_done_o
);
  wb_entry_t  open_q, open_d, single_e, grown_e;
  logic       open_v_q, open_v_d, sync_q, sync_d, drain_q, drain_d;
  st_class_e  cls;
  logic       match, closes;
  logic [OFS_W-1:0] ofs, open_ofs;

  always_comb begin
    if (!en_i || (!st_b_i && !st_c_i))             cls = CLS_SYNC;
    else if (!st_b_i && st_c_i && st_multi_i)      cls = CLS_MERGE;
    else                                           cls = CLS_POST;
  end

  assign ofs      = st_addr_i[LINE_LSB-1:2];
  assign open_ofs = open_q.addr[LINE_LSB-1:2];
  assign match    = open_v_q
                 && (st_addr_i[ADDR_W-1:LINE_LSB] == open_q.addr[ADDR_W-1:LINE_LSB])
                 && (CNT_W'(ofs) == CNT_W'(open_ofs) + open_q.cnt);
  assign closes   = st_last_i || (ofs == OFS_W'(LINE_WORDS - 1));

  always_comb begin
    single_e         = '0;
    single_e.addr    = st_addr_i;
    single_e.data[0] = st_data_i;
    single_e.cnt     = CNT_W'(1);
    grown_e          = open_q;
    grown_e.data[open_q.cnt[OFS_W-1:0]] = st_data_i;
    grown_e.cnt      = open_q.cnt + 1'b1;
    grown_e.burst    = 1'b1;
  end

  always_comb begin
    stall_o      = st_valid_i;
    push_o       = 1'b0;
    push_e_o     = open_q;
    open_v_d     = open_v_q;
    open_d       = open_q;
    sync_d       = sync_q;
    drain_d      = drain_q | drain_i;
    drain_done_o = 1'b0;
    if (drain_q) begin
      if (open_v_q) begin
        if (!q_full_i) begin push_o = 1'b1; open_v_d = 1'b0; end
      end else if (q_empty_i) begin
        drain_done_o = 1'b1;
        drain_d      = drain_i;
      end
    end else if (st_valid_i) begin
      if (open_v_q && !(cls == CLS_MERGE && match)) begin
        // queue the open merge first, newcomer waits a cycle
        if (!q_full_i) begin push_o = 1'b1; open_v_d = 1'b0; end
      end else begin
        case (cls)
          CLS_MERGE: begin
            if (closes) begin
              if (!q_full_i) begin
                push_o   = 1'b1;
                push_e_o = open_v_q ? grown_e : single_e;
                open_v_d = 1'b0;
                stall_o  = 1'b0;
              end
            end else begin
              stall_o  = 1'b0;
              open_v_d = 1'b1;
              open_d   = open_v_q ? grown_e : single_e;
            end
          end
          CLS_SYNC: begin
            if (!sync_q) begin
              if (!q_full_i) begin push_o = 1'b1; push_e_o = single_e; sync_d = 1'b1; end
            end else if (q_empty_i) begin
              stall_o = 1'b0;
              sync_d  = 1'b0;
            end
          end
          default: begin
            if (!q_full_i) begin push_o = 1'b1; push_e_o = single_e; stall_o = 1'b0; end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_v_q <= 1'b0;
      open_q   <= '0;
      sync_q   <= 1'b0;
      drain_q  <= 1'b0;
    end else begin
      open_v_q <= open_v_d;
      open_q   <= open_d;
      sync_q   <= sync_d;
      drain_q  <= drain_d;
    end
  end

  assert_sync_after_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !stall_o && cls == CLS_SYNC) |-> (q_empty_i && !open_v_q));
  assert_open_in_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_v_q |-> ((CNT_W'(open_ofs) + open_q.cnt) <= CNT_W'(LINE_WORDS - 1)));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_done_o && !drain_i) |=> !drain_done_o);
endmodule

// File: rtl/attr_wbuf.sv
module attr_wbuf import wbuf_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ctrl_we_i,
  input  logic                         ctrl_mmu_en_i,
  input  logic                         ctrl_wb_en_i,
  input  logic                         st_valid_i,
  input  logic [ADDR_W-1:0]            st_addr_i,
  input  logic [DATA_W-1:0]            st_data_i,
  input  logic                         st_b_i,
  input  logic                         st_c_i,
  input  logic                         st_multi_i,
  input  logic                         st_last_i,
  output logic                         stall_o,
  input  logic                         drain_i,
  output logic                         drain_done_o,
  output logic                         mem_req_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [LINE_WORDS*DATA_W-1:0] mem_data_o,
  output logic [CNT_W-1:0]             mem_len_o,
  output logic                         mem_burst_o,
  input  logic                         mem_done_i
);
  logic      mmu_q, wben_q, q_empty, q_full, push, pop;
  wb_entry_t push_e, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mmu_q  <= 1'b0;
      wben_q <= 1'b0;
    end else if (ctrl_we_i) begin
      mmu_q  <= ctrl_mmu_en_i;
      wben_q <= ctrl_wb_en_i;
    end
  end

  wbuf_front u_front (
    .clk_i, .rst_ni,
    .en_i        (mmu_q & wben_q),
    .st_valid_i, .st_addr_i, .st_data_i, .st_b_i, .st_c_i, .st_multi_i, .st_last_i,
    .drain_i,
    .q_full_i    (q_full),
    .q_empty_i   (q_empty),
    .stall_o,
    .push_o      (push),
    .push_e_o    (push_e),
    .drain_done_o
  );

  assign pop = mem_done_i & ~q_empty;

  wbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i   (push),
    .push_e_i (push_e),
    .pop_i    (pop),
    .head_o   (head),
    .empty_o  (q_empty),
    .full_o   (q_full)
  );

  assign mem_req_o   = ~q_empty;
  assign mem_addr_o  = head.addr;
  assign mem_data_o  = head.data;
  assign mem_len_o   = head.cnt;
  assign mem_burst_o = head.burst;

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_done_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o)
                                    && $stable(mem_data_o)));
  assert_burst_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_burst_o == (mem_len_o > CNT_W'(1))));
endmodule

// File: tb/attr_wbuf_bench.sv
module attr_wbuf_bench;
  import wbuf_pkg::*;

  logic clk = 0, rst_ni = 0;
  logic ctrl_we = 0, ctrl_mmu = 0, ctrl_wb = 0;
  logic st_valid = 0, st_b = 0, st_c = 0, st_multi = 0, st_last = 0;
  logic [31:0] st_addr = 0, st_data = 0;
  logic stall, drain = 0, drain_done, mem_req, mem_burst, mem_done = 0;
  logic [31:0] mem_addr;
  logic [255:0] mem_data;
  logic [3:0] mem_len;

  always #2 clk = ~clk;

  attr_wbuf u_attr_wbuf (
    .clk_i(clk), .rst_ni, .ctrl_we_i(ctrl_we), .ctrl_mmu_en_i(ctrl_mmu), .ctrl_wb_en_i(ctrl_wb),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_b_i(st_b), .st_c_i(st_c),
    .st_multi_i(st_multi), .st_last_i(st_last), .stall_o(stall), .drain_i(drain),
    .drain_done_o(drain_done), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_len_o(mem_len), .mem_burst_o(mem_burst), .mem_done_i(mem_done));

  int checks = 0, errors = 0, cyc = 0, ack_n = 0, lat = 0, w;
  bit en_m = 0, hold = 0, m_open = 0, prev_req = 0, prev_done = 0;
  logic [31:0] m_addr, prev_addr;
  int m_cnt;
  logic [255:0] m_data;
  logic [31:0]  ex_addr[$];
  int           ex_cnt[$];
  logic [255:0] ex_data[$];

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic m_flush();
    if (m_open) begin ex_addr.push_back(m_addr); ex_cnt.push_back(m_cnt); ex_data.push_back(m_data); end
    m_open = 0;
  endtask

  task automatic m_single(input logic [31:0] a, input logic [31:0] d);
    ex_addr.push_back(a); ex_cnt.push_back(1); ex_data.push_back({224'b0, d});
  endtask

  // memory responder and scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_req && !prev_done)
        chk(mem_req && mem_addr == prev_addr,
            $sformatf("R10 hold req=%0b addr=%h exp %h", mem_req, mem_addr, prev_addr));
      if (mem_done) begin
        mem_done = 0; lat = 0;
      end else if (mem_req && !hold) begin
        lat++;
        if (lat >= 2 + ack_n % 3) begin
          if (ex_addr.size() == 0) chk(0, $sformatf("R10 unexpected entry addr=%h exp none", mem_addr));
          else begin
            logic [31:0] ea; int ec; logic [255:0] ed;
            ea = ex_addr.pop_front(); ec = ex_cnt.pop_front(); ed = ex_data.pop_front();
            chk(mem_addr == ea && mem_len == 4'(ec) && mem_burst == (ec > 1) && mem_data == ed,
                $sformatf("R4 entry addr=%h len=%0d burst=%0b data=%h exp addr=%h len=%0d data=%h",
                          mem_addr, mem_len, mem_burst, mem_data, ea, ec, ed));
          end
          mem_done = 1; ack_n++;
        end
      end
    end
    prev_req = mem_req; prev_done = mem_done; prev_addr = mem_addr;
  end

  task automatic store(input logic [31:0] a, input logic [31:0] d, input bit b, input bit c,
                       input bit multi, input bit last, output int waits);
    bit sync, merge;
    sync  = !en_m || (!b && !c);
    merge = !sync && !b && c && multi;
    if (sync) begin m_flush(); m_single(a, d); end
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_b = b; st_c = c; st_multi = multi; st_last = last;
    waits = 0;
    #1;
    while (stall) begin @(negedge clk); #1; waits++; end
    @(posedge clk);
    if (sync) chk(ex_addr.size() == 0, $sformatf("R3 pending at accept=%0d exp 0", ex_addr.size()));
    else if (merge) begin
      if (!(m_open && a[31:5] == m_addr[31:5] && a == m_addr + 32'(4 * m_cnt))) begin
        m_flush(); m_open = 1; m_addr = a; m_cnt = 0; m_data = '0;
      end
      m_data[m_cnt*32 +: 32] = d; m_cnt++;
      if (last || a[4:2] == 3'd7) m_flush();
    end else begin m_flush(); m_single(a, d); end
    #1 st_valid = 0;
  endtask

  task automatic ctrl(input bit mmu, input bit wb);
    @(negedge clk); ctrl_we = 1; ctrl_mmu = mmu; ctrl_wb = wb;
    @(posedge clk); #1 ctrl_we = 0; en_m = mmu && wb;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mem_req || ex_addr.size() != 0);
  endtask

  task automatic do_drain();
    int n = 0;
    m_flush();
    @(negedge clk); drain = 1;
    @(posedge clk); #1 drain = 0;
    do begin @(negedge clk); #1; n++; end while (!drain_done && n < 200);
    chk(drain_done && ex_addr.size() == 0,
        $sformatf("R8 done=%0b pending=%0d exp 1/0", drain_done, ex_addr.size()));
    @(negedge clk); #1;
    chk(!drain_done, $sformatf("R8 pulse width done=%0b exp 0", drain_done));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; $display("FAIL watchdog cycles=%0d exp <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
    end
  end

  initial begin
    #1;
    chk(!mem_req && !drain_done && !stall,
        $sformatf("R11 reset req=%0b done=%0b stall=%0b exp 0", mem_req, drain_done, stall));
    @(negedge clk); rst_ni = 1;
    // R6: disabled, then buffer bit alone, then both
    store(32'h10, 32'hA1, 1, 0, 0, 0, w);
    chk(w > 0, $sformatf("R6 reset-disabled waits=%0d exp >0", w));
    ctrl(0, 1);
    store(32'h14, 32'hA2, 1, 0, 0, 0, w);
    chk(w > 0, $sformatf("R6 mmu-off waits=%0d exp >0", w));
    ctrl(1, 1);
    for (int i = 0; i < 3; i++) begin
      store(32'h20 + 32'(8*i), 32'hB0 + 32'(i), 1, 0, 0, 0, w);
      chk(w == 0, $sformatf("R1 posted waits=%0d exp 0", w));
    end
    // R2: posted store multiple stays unmerged
    for (int i = 0; i < 4; i++) begin
      store(32'h100 + 32'(4*i), 32'hC0 + 32'(i), 1, 0, 1, i == 3, w);
      chk(w == 0, $sformatf("R2 word waits=%0d exp 0", w));
    end
    wait_idle();
    // R4: merged burst
    for (int i = 0; i < 4; i++) begin
      store(32'h300 + 32'(4*i), 32'hD0 + 32'(i), 0, 1, 1, i == 3, w);
      chk(w == 0, $sformatf("R4 merge waits=%0d exp 0", w));
    end
    // R5: line end closes, then skipped address breaks
    store(32'h118, 32'hE0, 0, 1, 1, 0, w);
    store(32'h11C, 32'hE1, 0, 1, 1, 0, w);
    store(32'h120, 32'hE2, 0, 1, 1, 0, w);
    store(32'h124, 32'hE3, 0, 1, 1, 1, w);
    store(32'h200, 32'hF0, 0, 1, 1, 0, w);
    store(32'h208, 32'hF1, 0, 1, 1, 0, w);
    chk(w > 0, $sformatf("R5 break flush waits=%0d exp >0", w));
    store(32'h20C, 32'hF2, 0, 1, 1, 1, w);
    for (int i = 0; i < 8; i++) store(32'h400 + 32'(4*i), 32'h400 + 32'(i), 0, 1, 1, i == 7, w);
    wait_idle();
    // R3: sync behind posted, and behind an open merge
    store(32'h700, 32'h1, 1, 0, 0, 0, w);
    store(32'h704, 32'h2, 1, 0, 0, 0, w);
    store(32'h708, 32'h3, 0, 0, 0, 0, w);
    chk(w > 0, $sformatf("R3 sync waits=%0d exp >0", w));
    store(32'h500, 32'h5, 0, 1, 1, 0, w);
    store(32'h504, 32'h6, 0, 1, 1, 0, w);
    store(32'h800, 32'h7, 0, 0, 0, 0, w);
    chk(w > 0, $sformatf("R3 sync after merge waits=%0d exp >0", w));
    // R9: full queue stalls
    wait_idle();
    hold = 1;
    for (int i = 0; i < 8; i++) begin
      store(32'h900 + 32'(4*i), 32'h90 + 32'(i), 1, 0, 0, 0, w);
      chk(w == 0, $sformatf("R9 fill waits=%0d exp 0", w));
    end
    fork
      store(32'h940, 32'h99, 1, 0, 0, 0, w);
      begin
        repeat (4) @(negedge clk);
        #1 chk(stall, $sformatf("R9 full stall=%0b exp 1", stall));
        hold = 0;
      end
    join
    chk(w > 0, $sformatf("R9 ninth waits=%0d exp >0", w));
    // R7: disable with pending entries
    wait_idle();
    hold = 1;
    for (int i = 0; i < 3; i++) store(32'hA00 + 32'(4*i), 32'hA0 + 32'(i), 1, 0, 0, 0, w);
    ctrl(1, 0);
    hold = 0;
    wait_idle();
    chk(ex_addr.size() == 0, $sformatf("R7 lost entries=%0d exp 0", ex_addr.size()));
    store(32'hA40, 32'hAA, 1, 0, 0, 0, w);
    chk(w > 0, $sformatf("R7 disabled sync waits=%0d exp >0", w));
    ctrl(1, 1);
    // R8: drain with open merge, then with nothing held
    store(32'h600, 32'h61, 0, 1, 1, 0, w);
    store(32'h604, 32'h62, 0, 1, 1, 0, w);
    do_drain();
    do_drain();
    wait_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule